// File: doc/BRIEF.md
# Timestamped Sample Cluster Decoder

This block turns a byte-serial capture memory chunk into a stream of 16-bit sample words. A chunk is a run of fixed-size clusters. Each cluster opens with a 16-bit timestamp and then carries a fixed number of 16-bit events spaced one timestamp tick apart. Depending on the rate mode, an event packs one, two or four samples taken one after another, for sixteen, eight or four channels. The timestamps make the capture run-length compressed. When two clusters lie further apart than one cluster's worth of ticks, the decoder fills the idle span by repeating the most recent sample before it unpacks the new cluster.

Bytes arrive on a valid/ready input and samples leave on a valid/ready output. A sideband flag marks the first chunk of a capture. The rate mode and an optional limit timestamp are taken with the first byte of each chunk. The limit lets the caller cut a partially written final chunk short.

Top module: `cluster_decoder`

## Requirements
- R1: `rateMode` 0 gives 16 channels and 1 sample per event, where the sample equals the event. Mode 1 gives 8 channels and 2 samples per event, where channel l of sample k is event bit 2l+k. Modes 2 and 3 give 4 channels and 4 samples per event, where channel l of sample k is event bit 4l+k. Unused upper sample bits are 0.
- R2: A cluster is 2+2·EVENTS bytes. Byte 0 is the timestamp low byte and byte 1 the high byte. Bytes 2e+2 and 2e+3 are the low and high bytes of event e. Events are emitted in order, and samples within an event in increasing k.
- R3: Before unpacking a cluster, diff = (ts − previous ts) mod 2^16. When diff > EVENTS, exactly (diff − EVENTS)·samplesPerEvent copies of the last sample are emitted first; otherwise none are.
- R4: The last sample is the final sample emitted from the most recently unpacked cluster. It carries across chunk boundaries.
- R5: When `firstChunk` is high with byte 0 of a chunk, the last sample is cleared to 0 and no padding precedes that chunk's first cluster.
- R6: With a nonzero limit and a cluster timestamp above it, that cluster and the rest of the chunk produce no samples, but all remaining bytes are still accepted. That timestamp still becomes the previous timestamp. A limit of 0 disables the check.
- R7: While `outValid` is high and `outReady` is low, `outValid` stays high and `outSample` stays unchanged, and no sample is lost or repeated.
- R8: `inReady` and `outValid` are never high together.
- R9: During and right after reset, `outValid` is 0 and `inReady` is 1.
- R10: `rateMode` and `limitTs` are captured with byte 0 of each chunk. Changing them later in the chunk has no effect on that chunk.
- R11: Timestamp differences wrap at 16 bits, so a timestamp sequence crossing 0xFFFF→0x0000 pads the same as one that does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inByte | input | 8 | Chunk byte |
| inValid | input | 1 | Byte present |
| inReady | output | 1 | Byte accepted this cycle when high with inValid |
| firstChunk | input | 1 | Marks byte 0 of the first chunk of a capture |
| rateMode | input | 2 | Rate mode, captured at byte 0 of a chunk |
| limitTs | input | 16 | Limit timestamp (0 = none), captured at byte 0 |
| outSample | output | 16 | Decoded or padding sample |
| outValid | output | 1 | Sample present |
| outReady | input | 1 | Sink takes the sample |

## Verification
The hardest state to reach is a cleared last sample that is then used as padding. In a first chunk, cluster 0 is never padded and its events overwrite the cleared value at once. The stimulus therefore gives a first chunk a limit below its first timestamp, so nothing is decoded. It follows with a chunk whose first gap must be filled with zeros. Stalls on the output are mixed into the table runs, so that padding and unpacking are both interrupted. A separate run changes the mode and limit inputs in the middle of a chunk and crosses the 16-bit timestamp wrap.

// File: rtl/cluster_dec_pkg.sv
package cluster_dec_pkg;

  localparam int TS_W = 16;
  localparam int EV_W = 16;
  localparam int SAMPLE_W = 16;

  typedef enum logic [1:0] {
    MODE_CH16 = 2'd0,
    MODE_CH8  = 2'd1,
    MODE_CH4  = 2'd2,
    MODE_CH4B = 2'd3
  } rateMode_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic chunkStart;
    logic tsLoLoad;
    logic tsLoad;
    logic evLoLoad;
    logic evHiLoad;
    logic padStep;
    logic sampleStep;
    logic selPad;
  } dpStrobes_t;

  // log2 of samples per event
  function automatic logic [1:0] speLog2(input logic [1:0] m);
    case (m)
      MODE_CH16: speLog2 = 2'd0;
      MODE_CH8:  speLog2 = 2'd1;
      default:   speLog2 = 2'd2;
    endcase
  endfunction

  function automatic logic [SAMPLE_W-1:0] unpackSample(input logic [EV_W-1:0] ev,
                                                       input logic [1:0] m,
                                                       input logic [1:0] k);
    logic [SAMPLE_W-1:0] s;
    s = '0;
    case (m)
      MODE_CH16: s = ev;
      MODE_CH8: begin
        for (int l = 0; l < 8; l++) s[l] = ev[2*l + int'(k[0])];
      end
      default: begin
        for (int l = 0; l < 4; l++) s[l] = ev[4*l + int'(k)];
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cluster_dec_ctrl.sv
module cluster_dec_ctrl
  import cluster_dec_pkg::*;
#(
  parameter int CLUSTERS = 64,
  parameter int EVENTS   = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  input  logic       padNeeded,
  input  logic       overLimit,
  input  logic       padLast,
  input  logic [1:0] kLast,
  output logic       inReady,
  output logic       outValid,
  output logic [1:0] kIdx,
  output dpStrobes_t strobes
);

  localparam int BPC   = 2 + 2 * EVENTS;
  localparam int POS_W = $clog2(BPC);
  localparam int CL_W  = (CLUSTERS > 1) ? $clog2(CLUSTERS) : 1;

  typedef enum logic [1:0] {ST_RECV, ST_PAD, ST_EMIT, ST_DROP} state_e;

  state_e state;
  logic [POS_W-1:0] posIdx;
  logic [CL_W-1:0]  clIdx;
  logic accept, recvAcc, fire, posLast, chunkEnd;

  assign inReady  = (state == ST_RECV) || (state == ST_DROP);
  assign outValid = (state == ST_PAD) || (state == ST_EMIT);
  assign accept   = inValid && inReady;
  assign recvAcc  = accept && (state == ST_RECV);
  assign fire     = outValid && outReady;
  assign posLast  = (posIdx == POS_W'(BPC - 1));
  assign chunkEnd = posLast && (clIdx == CL_W'(CLUSTERS - 1));

  always_comb begin
    strobes            = '0;
    strobes.chunkStart = recvAcc && (posIdx == '0) && (clIdx == '0);
    strobes.tsLoLoad   = recvAcc && (posIdx == POS_W'(0));
    strobes.tsLoad     = recvAcc && (posIdx == POS_W'(1));
    strobes.evLoLoad   = recvAcc && (posIdx >= POS_W'(2)) && !posIdx[0];
    strobes.evHiLoad   = recvAcc && (posIdx >= POS_W'(3)) && posIdx[0];
    strobes.padStep    = (state == ST_PAD) && fire;
    strobes.sampleStep = (state == ST_EMIT) && fire;
    strobes.selPad     = (state == ST_PAD);
  end

  // byte position inside the chunk
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posIdx <= '0;
      clIdx  <= '0;
    end else if (accept) begin
      if (posLast) begin
        posIdx <= '0;
        clIdx  <= (clIdx == CL_W'(CLUSTERS - 1)) ? '0 : clIdx + 1'b1;
      end else begin
        posIdx <= posIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RECV;
      kIdx  <= '0;
    end else begin
      case (state)
        ST_RECV: begin
          if (strobes.tsLoad) begin
            if (overLimit)      state <= ST_DROP;
            else if (padNeeded) state <= ST_PAD;
          end
          if (strobes.evHiLoad) begin
            state <= ST_EMIT;
            kIdx  <= '0;
          end
        end
        ST_PAD: begin
          if (fire && padLast) state <= ST_RECV;
        end
        ST_EMIT: begin
          if (fire) begin
            if (kIdx == kLast) state <= ST_RECV;
            else kIdx <= kIdx + 1'b1;
          end
        end
        ST_DROP: begin
          if (accept && chunkEnd) state <= ST_RECV;
        end
        default: state <= ST_RECV;
      endcase
    end
  end

endmodule

// File: rtl/cluster_dec_dp.sv
module cluster_dec_dp
  import cluster_dec_pkg::*;
#(
  parameter int EVENTS = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobes_t          strobes,
  input  logic [7:0]          inByte,
  input  logic                inFirst,
  input  logic [1:0]          modeIn,
  input  logic [TS_W-1:0]     limitIn,
  input  logic [1:0]          kIdx,
  output logic                padNeeded,
  output logic                overLimit,
  output logic                padLast,
  output logic [1:0]          kLast,
  output logic [SAMPLE_W-1:0] sample
);

  localparam int PAD_W = TS_W + 3;

  logic [1:0]          modeReg;
  logic [TS_W-1:0]     limitReg;
  logic                firstFlag;
  logic [7:0]          tsLo;
  logic [TS_W-1:0]     lastTs;
  logic [SAMPLE_W-1:0] lastSample;
  logic [PAD_W-1:0]    padCnt;
  logic [7:0]          evLo;
  logic [EV_W-1:0]     evReg;

  logic [TS_W-1:0]     tsNow, diff;
  logic [1:0]          shamt;
  logic [PAD_W-1:0]    padBase, padInit;
  logic [SAMPLE_W-1:0] unpacked;

  assign tsNow     = {inByte, tsLo};
  assign diff      = tsNow - lastTs;
  assign shamt     = speLog2(modeReg);
  assign kLast     = 2'(({1'b0, 2'b01} << shamt) - 3'd1);
  assign padBase   = {{(PAD_W-TS_W){1'b0}}, diff - TS_W'(EVENTS)};
  assign padInit   = padBase << shamt;
  assign padNeeded = !firstFlag && (diff > TS_W'(EVENTS));
  assign overLimit = (limitReg != '0) && (tsNow > limitReg);
  assign padLast   = (padCnt == PAD_W'(1));
  assign unpacked  = unpackSample(evReg, modeReg, kIdx);
  assign sample    = strobes.selPad ? lastSample : unpacked;

  // per-chunk settings
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= MODE_CH16;
      limitReg <= '0;
    end else if (strobes.chunkStart) begin
      modeReg  <= modeIn;
      limitReg <= limitIn;
    end
  end

  // timestamp tracking and padding
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstFlag <= 1'b0;
      tsLo      <= '0;
      lastTs    <= '0;
      padCnt    <= '0;
    end else begin
      if (strobes.chunkStart && inFirst) firstFlag <= 1'b1;
      if (strobes.tsLoLoad) tsLo <= inByte;
      if (strobes.tsLoad) begin
        lastTs    <= tsNow;
        firstFlag <= 1'b0;
        padCnt    <= padNeeded ? padInit : '0;
      end else if (strobes.padStep) begin
        padCnt <= padCnt - 1'b1;
      end
    end
  end

  // event assembly and last sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evLo       <= '0;
      evReg      <= '0;
      lastSample <= '0;
    end else begin
      if (strobes.evLoLoad) evLo <= inByte;
      if (strobes.evHiLoad) evReg <= {inByte, evLo};
      if (strobes.chunkStart && inFirst) lastSample <= '0;
      else if (strobes.sampleStep) lastSample <= unpacked;
    end
  end

endmodule

// File: rtl/cluster_decoder.sv
module cluster_decoder
  import cluster_dec_pkg::*;
#(
  parameter int CLUSTERS = 64,
  parameter int EVENTS   = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          inByte,
  input  logic                inValid,
  output logic                inReady,
  input  logic                firstChunk,
  input  logic [1:0]          rateMode,
  input  logic [TS_W-1:0]     limitTs,
  output logic [SAMPLE_W-1:0] outSample,
  output logic                outValid,
  input  logic                outReady
);

  dpStrobes_t strobes;
  logic padNeeded, overLimit, padLast;
  logic [1:0] kLast, kIdx;

  cluster_dec_ctrl #(.CLUSTERS(CLUSTERS), .EVENTS(EVENTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .padNeeded(padNeeded), .overLimit(overLimit), .padLast(padLast),
    .kLast(kLast), .inReady(inReady), .outValid(outValid),
    .kIdx(kIdx), .strobes(strobes)
  );

  cluster_dec_dp #(.EVENTS(EVENTS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inByte(inByte),
    .inFirst(firstChunk), .modeIn(rateMode), .limitIn(limitTs),
    .kIdx(kIdx), .padNeeded(padNeeded), .overLimit(overLimit),
    .padLast(padLast), .kLast(kLast), .sample(outSample)
  );

endmodule

// File: rtl/cluster_decoder_chk.sv
module cluster_decoder_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic [15:0] outSample
);

  p_hold_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  p_hold_sample_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outSample));

  p_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

  // output activity only starts right after a byte was taken
  p_rise_after_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(inValid && inReady));

  p_reset_r9: assert property (@(posedge clk)
    !rstN |=> (!outValid && inReady));

endmodule

bind cluster_decoder cluster_decoder_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outSample(outSample)
);

// File: tb/cluster_decoder_tb.sv
`timescale 1ns/1ps
module cluster_decoder_tb;

  localparam int NCL = 64;
  localparam int NEV = 7;
  localparam int BPC = 2 + 2 * NEV;
  localparam int CHUNK = NCL * BPC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] inByte = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic firstChunk = 1'b0;
  logic [1:0] rateMode = '0;
  logic [15:0] limitTs = '0;
  logic [15:0] outSample;
  logic outValid;
  logic outReady = 1'b1;

  always #2.5 clk = ~clk;

  cluster_decoder u_dut (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inValid(inValid), .inReady(inReady),
    .firstChunk(firstChunk), .rateMode(rateMode), .limitTs(limitTs),
    .outSample(outSample), .outValid(outValid), .outReady(outReady)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        first;
    logic        absBase;
    logic [15:0] base;
    logic [7:0]  step;
    logic [6:0]  gapAt;
    logic [15:0] gapLen;
    logic [7:0]  limitAt;   // 8'hFF: no limit
    logic [3:0]  stall;     // 0: sink always ready
    logic        flip;      // change mode/limit inputs mid-chunk
    logic [15:0] seed;
  } scen_t;

  localparam int NSCEN = 10;
  localparam scen_t SCEN [NSCEN] = '{
    '{mode:2'd0, first:1'b1, absBase:1'b1, base:16'd100, step:8'd7, gapAt:7'd64, gapLen:16'd0,  limitAt:8'hFF, stall:4'd0, flip:1'b0, seed:16'd1},
    '{mode:2'd1, first:1'b0, absBase:1'b0, base:16'd9,   step:8'd9, gapAt:7'd10, gapLen:16'd40, limitAt:8'hFF, stall:4'd3, flip:1'b0, seed:16'd2},
    '{mode:2'd2, first:1'b0, absBase:1'b0, base:16'd12,  step:8'd8, gapAt:7'd63, gapLen:16'd20, limitAt:8'hFF, stall:4'd0, flip:1'b0, seed:16'd3},
    '{mode:2'd3, first:1'b0, absBase:1'b0, base:16'd7,   step:8'd7, gapAt:7'd64, gapLen:16'd0,  limitAt:8'hFF, stall:4'd4, flip:1'b0, seed:16'd4},
    '{mode:2'd0, first:1'b1, absBase:1'b1, base:16'hFFE0, step:8'd8, gapAt:7'd64, gapLen:16'd0, limitAt:8'hFF, stall:4'd0, flip:1'b0, seed:16'd5},
    '{mode:2'd1, first:1'b0, absBase:1'b0, base:16'd9,   step:8'd9, gapAt:7'd64, gapLen:16'd0,  limitAt:8'd20, stall:4'd2, flip:1'b0, seed:16'd6},
    '{mode:2'd2, first:1'b0, absBase:1'b0, base:16'd10,  step:8'd8, gapAt:7'd64, gapLen:16'd0,  limitAt:8'hFF, stall:4'd2, flip:1'b1, seed:16'd7},
    '{mode:2'd0, first:1'b0, absBase:1'b0, base:16'd30,  step:8'd10, gapAt:7'd64, gapLen:16'd0, limitAt:8'hFF, stall:4'd0, flip:1'b0, seed:16'd8},
    '{mode:2'd0, first:1'b1, absBase:1'b1, base:16'd1000, step:8'd7, gapAt:7'd64, gapLen:16'd0, limitAt:8'd0,  stall:4'd0, flip:1'b0, seed:16'd9},
    '{mode:2'd0, first:1'b0, absBase:1'b0, base:16'd20,  step:8'd7, gapAt:7'd64, gapLen:16'd0,  limitAt:8'hFF, stall:4'd0, flip:1'b0, seed:16'd10}
  };

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]  chunkBuf [CHUNK];
  logic [15:0] expQ [$];
  logic [15:0] refLastTs = '0;
  logic [15:0] refLastSample = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string tagOf(input int i);
    case (i)
      0: return "R1 R2 mode0";
      1: return "R1 R3 R7 mode1 gap";
      2: return "R1 R3 mode2 gap";
      3: return "R1 R7 mode3";
      4: return "R5 R11 wrap";
      5: return "R6 limit";
      6: return "R10 mid-chunk change";
      7: return "R4 after drop";
      8: return "R5 R6 first chunk cut";
      9: return "R5 zero padding";
      default: return "R?";
    endcase
  endfunction

  function automatic logic [15:0] tsAt(input int c);
    return {chunkBuf[c*BPC + 1], chunkBuf[c*BPC]};
  endfunction

  task automatic buildChunk(input logic [15:0] base, input int step, input int gapAt,
                            input int gapLen, input int seed);
    for (int c = 0; c < NCL; c++) begin
      logic [15:0] ts;
      ts = 16'(int'(base) + c * step + ((c >= gapAt) ? gapLen : 0));
      chunkBuf[c*BPC]     = ts[7:0];
      chunkBuf[c*BPC + 1] = ts[15:8];
      for (int e = 0; e < NEV; e++) begin
        logic [15:0] ev;
        ev = 16'(seed * 4099 + c * 733 + e * 2659) ^ 16'(c * e * 97 + seed);
        chunkBuf[c*BPC + 2 + 2*e] = ev[7:0];
        chunkBuf[c*BPC + 3 + 2*e] = ev[15:8];
      end
    end
  endtask

  // expected stream straight from the requirements
  task automatic modelChunk(input int mode, input bit first, input logic [15:0] limit);
    int spe;
    spe = (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
    if (first) refLastSample = '0;
    for (int c = 0; c < NCL; c++) begin
      logic [15:0] ts, diff;
      ts = tsAt(c);
      diff = (first && c == 0) ? 16'd1 : 16'(ts - refLastTs);
      refLastTs = ts;
      if (limit != 0 && ts > limit) break;
      if (diff > NEV)
        for (int p = 0; p < (int'(diff) - NEV) * spe; p++) expQ.push_back(refLastSample);
      for (int e = 0; e < NEV; e++) begin
        logic [15:0] ev;
        ev = {chunkBuf[c*BPC + 3 + 2*e], chunkBuf[c*BPC + 2 + 2*e]};
        for (int k = 0; k < spe; k++) begin
          logic [15:0] s;
          s = '0;
          for (int l = 0; l < 16 / spe; l++) s[l] = ev[l*spe + k];
          expQ.push_back(s);
          refLastSample = s;
        end
      end
    end
  endtask

  task automatic runChunk(input int idx);
    scen_t sc;
    logic [15:0] base, limit, held;
    int ptr, cyc, stallChecks;
    bit heldValid, exclBad;
    string tag;
    sc = SCEN[idx];
    tag = tagOf(idx);
    base = sc.absBase ? sc.base : 16'(refLastTs + sc.base);
    buildChunk(base, int'(sc.step), int'(sc.gapAt), int'(sc.gapLen), int'(sc.seed));
    limit = (sc.limitAt == 8'hFF) ? 16'd0 : 16'(tsAt(int'(sc.limitAt)) - 16'd1);
    modelChunk(int'(sc.mode), sc.first, limit);
    ptr = 0; cyc = 0; heldValid = 0; exclBad = 0; held = '0; stallChecks = 0;
    while ((ptr < CHUNK || expQ.size() > 0 || outValid) && cyc < 60000) begin
      @(negedge clk);
      inValid    = (ptr < CHUNK);
      inByte     = (ptr < CHUNK) ? chunkBuf[ptr] : 8'h00;
      firstChunk = sc.first && (ptr == 0);
      rateMode   = (sc.flip && ptr >= 500) ? (sc.mode ^ 2'd1) : sc.mode;
      limitTs    = (sc.flip && ptr >= 500) ? 16'd1 : limit;
      outReady   = (sc.stall == 0) ? 1'b1 : ((cyc % int'(sc.stall)) != 0);
      #1;
      if (inReady && outValid) exclBad = 1;
      if (heldValid && stallChecks < 20) begin
        // R7: a stalled sample stays put
        check(outValid && outSample == held, {tag, " R7 stalled sample"}, {15'd0, outValid, outSample}, {16'd1, held});
        stallChecks++;
      end
      heldValid = outValid && !outReady;
      held = outSample;
      if (inValid && inReady) ptr++;
      if (outValid && outReady) begin
        if (expQ.size() == 0) check(0, {tag, " R3 extra sample"}, outSample, 32'hFFFF_FFFF);
        else begin
          logic [15:0] exp;
          exp = expQ.pop_front();
          check(outSample == exp, {tag, " sample"}, outSample, exp);
        end
      end
      cyc++;
    end
    @(negedge clk);
    inValid = 0; firstChunk = 0; outReady = 1;
    check(expQ.size() == 0 && ptr == CHUNK, {tag, " R6 count/consumed"}, expQ.size(), 0);
    check(!exclBad, {tag, " R8 ready/valid overlap"}, exclBad, 0);
    expQ.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1;
    check(!outValid && inReady, "R9 in reset", {outValid, inReady}, 2'b01);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(!outValid && inReady, "R9 after reset", {outValid, inReady}, 2'b01);
    for (int i = 0; i < NSCEN; i++) runChunk(i);
    // idle: no bytes means no samples
    repeat (10) @(negedge clk);
    #1;
    check(!outValid && inReady, "R9 idle after run", {outValid, inReady}, 2'b01);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule